// File: doc/BRIEF.md
# Per-Bit Access Policy Register

This block is a single parameterised control and status register in which every bit follows its own access rule. Mask parameters sort the bits into classes: bits that software can never write, bits that software clears by writing a one, bits that a read clears, reserved bits, and plain read/write bits that appear in none of these masks. Two more masks mark bits where software is not allowed to write a given value. When a write puts a forbidden value into one of those bits, the block raises a one-cycle error pulse.

Software reaches the register through a write strobe with data and a per-bit enable mask, and through a read strobe. The stored value is always visible on the read data port. Hardware logic sets bits through a per-bit set input. A hardware set wins over every software action in the same cycle, so a status event that arrives together with a clearing access is kept.

Top module: `policy_reg`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the register holds the parameter RESET_VAL and both error outputs are 0.
- R2: A bit in RO_MASK never changes because of a write or a read. Only the hardware set input can change it.
- R3: On a write, a bit in W1C_MASK (and not in RO_MASK or RSVD_MASK) becomes 0 when its enabled data bit is 1, and is kept when the data bit is 0.
- R4: rd_data shows the current value during a read cycle. A bit in COR_MASK that is not in RO_MASK becomes 0 at the clock edge that ends a read cycle. This clear is applied after any write in the same cycle.
- R5: A bit in RSVD_MASK (and not in RO_MASK) keeps its value on every write.
- R6: A write affects only the bits whose wr_mask bit is 1. The other bits keep their value, apart from read clears and hardware sets.
- R7: A bit in none of RO_MASK, RSVD_MASK and W1C_MASK takes the enabled written data bit at the write edge. This holds even if the bit is in COR_MASK.
- R8: err_one is 1 for exactly the cycle after a write edge at which some bit had wr_mask=1, wr_data=1 and ERR1_MASK=1. Otherwise it is 0.
- R9: err_zero is 1 for exactly the cycle after a write edge at which some bit had wr_mask=1, wr_data=0 and ERR0_MASK=1. Otherwise it is 0. An erroneous write is still applied to the writable bits.
- R10: A 1 on hw_set sets that bit at the next edge. This takes priority over a write-one-clear, a read clear, a plain write of 0 and the read-only rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | WIDTH | Write data |
| wr_mask | input | WIDTH | Per-bit write enable |
| rd_en | input | 1 | Read strobe; fires the clear of clear-on-read bits |
| rd_data | output | WIDTH | Current register value |
| hw_set | input | WIDTH | Per-bit hardware set, highest priority |
| err_one | output | 1 | Pulse: a forbidden one was written |
| err_zero | output | 1 | Pulse: a forbidden zero was written |

## Verification
The bench builds the block 16 bits wide, with a reset value of 0xA5C3 and these masks:

| Mask | Value | Bits |
|---|---|---|
| RO_MASK | 0xF000 | 15:12, read-only |
| W1C_MASK | 0x0F00 | 11:8, write-one-clear |
| COR_MASK | 0x81F0 | 15, 8 and 7:4, clear-on-read |
| RSVD_MASK | 0x000C | 3:2, reserved |
| ERR1_MASK | 0x0002 | 1, writing a one is an error |
| ERR0_MASK | 0x0001 | 0, writing a zero is an error |

Bit 15 is both read-only and clear-on-read, so the bench can show that the read-only rule wins. Bit 8 is both write-one-clear and clear-on-read, so a write and a read in the same cycle exercise the order of the two clears. Random accesses mix reads, writes and hardware sets on every bit class, so sets that collide with clears come up often alongside the directed cases.

// File: rtl/policy_reg_pkg.sv
package policy_reg_pkg;

  // How a software write treats one bit
  typedef enum logic [1:0] {
    CLS_RW   = 2'd0,
    CLS_W1C  = 2'd1,
    CLS_HOLD = 2'd2
  } wr_cls_e;

  // Read-only and reserved outrank write-one-clear
  function automatic wr_cls_e classify(logic ro, logic rsvd, logic w1c);
    if (ro || rsvd) return CLS_HOLD;
    if (w1c)        return CLS_W1C;
    return CLS_RW;
  endfunction

  // Next value of one bit: write, then read clear, then hardware set
  function automatic logic bit_next(wr_cls_e cls, logic q, logic wsel,
                                    logic wd, logic rclr, logic hset);
    logic v;
    v = q;
    if (wsel) begin
      case (cls)
        CLS_RW:  v = wd;
        CLS_W1C: if (wd) v = 1'b0;
        default: v = q;
      endcase
    end
    if (rclr) v = 1'b0;
    if (hset) v = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/policy_reg_bits.sv
module policy_reg_bits #(
  parameter int              WIDTH     = 32,
  parameter logic [WIDTH-1:0] RO_MASK   = '0,
  parameter logic [WIDTH-1:0] W1C_MASK  = '0,
  parameter logic [WIDTH-1:0] RSVD_MASK = '0
) (
  input  logic [WIDTH-1:0] q,
  input  logic [WIDTH-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] rd_clr,
  input  logic [WIDTH-1:0] hw_set,
  output logic [WIDTH-1:0] nxt
);
  import policy_reg_pkg::*;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    localparam wr_cls_e CLS = classify(RO_MASK[i], RSVD_MASK[i], W1C_MASK[i]);
    always_comb nxt[i] = bit_next(CLS, q[i], wr_sel[i], wr_data[i], rd_clr[i], hw_set[i]);
  end
endmodule

// File: rtl/policy_reg_errdet.sv
module policy_reg_errdet #(
  parameter int              WIDTH     = 32,
  parameter logic [WIDTH-1:0] ERR1_MASK = '0,
  parameter logic [WIDTH-1:0] ERR0_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wr_sel,
  input  logic [WIDTH-1:0] wr_data,
  output logic             err_one,
  output logic             err_zero
);
  logic hit_one, hit_zero;

  always_comb begin
    hit_one  = |(wr_sel & wr_data & ERR1_MASK);
    hit_zero = |(wr_sel & ~wr_data & ERR0_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_one  <= 1'b0;
      err_zero <= 1'b0;
    end else begin
      err_one  <= hit_one;
      err_zero <= hit_zero;
    end
  end
endmodule

// File: rtl/policy_reg.sv
module policy_reg #(
  parameter int              WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = 32'hA500_0000,
  parameter logic [WIDTH-1:0] RO_MASK   = 32'hFF00_0000,
  parameter logic [WIDTH-1:0] W1C_MASK  = 32'h00FF_0000,
  parameter logic [WIDTH-1:0] COR_MASK  = 32'h0000_F000,
  parameter logic [WIDTH-1:0] RSVD_MASK = 32'h0000_0F00,
  parameter logic [WIDTH-1:0] ERR1_MASK = 32'h0000_0080,
  parameter logic [WIDTH-1:0] ERR0_MASK = 32'h0000_0040
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [WIDTH-1:0] wr_mask,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  input  logic [WIDTH-1:0] hw_set,
  output logic             err_one,
  output logic             err_zero
);
  // Read-only bits are never cleared by a read
  localparam logic [WIDTH-1:0] COR_EFF = COR_MASK & ~RO_MASK;

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] state_nxt;
  logic [WIDTH-1:0] wr_sel;   // bits a write addresses this cycle
  logic [WIDTH-1:0] rd_clr;   // bits a read clears this cycle

  always_comb begin
    wr_sel = wr_en ? wr_mask : '0;
    rd_clr = rd_en ? COR_EFF : '0;
  end

  policy_reg_bits #(
    .WIDTH(WIDTH), .RO_MASK(RO_MASK), .W1C_MASK(W1C_MASK), .RSVD_MASK(RSVD_MASK)
  ) i_bits (
    .q(state_q), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_clr(rd_clr), .hw_set(hw_set), .nxt(state_nxt)
  );

  policy_reg_errdet #(
    .WIDTH(WIDTH), .ERR1_MASK(ERR1_MASK), .ERR0_MASK(ERR0_MASK)
  ) i_err (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wr_data(wr_data),
    .err_one(err_one), .err_zero(err_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RESET_VAL;
    else        state_q <= state_nxt;
  end

  assign rd_data = state_q;
endmodule

// File: rtl/policy_reg_checker.sv
module policy_reg_checker #(
  parameter int              WIDTH     = 32,
  parameter logic [WIDTH-1:0] RESET_VAL = '0,
  parameter logic [WIDTH-1:0] RO_MASK   = '0,
  parameter logic [WIDTH-1:0] W1C_MASK  = '0,
  parameter logic [WIDTH-1:0] COR_MASK  = '0,
  parameter logic [WIDTH-1:0] RSVD_MASK = '0,
  parameter logic [WIDTH-1:0] ERR1_MASK = '0,
  parameter logic [WIDTH-1:0] ERR0_MASK = '0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [WIDTH-1:0] wr_data,
  input logic [WIDTH-1:0] wr_mask,
  input logic             rd_en,
  input logic [WIDTH-1:0] rd_data,
  input logic [WIDTH-1:0] hw_set,
  input logic             err_one,
  input logic             err_zero
);
  localparam logic [WIDTH-1:0] CLR_ON_RD = COR_MASK & ~RO_MASK;
  localparam logic [WIDTH-1:0] W1C_EFF   = W1C_MASK & ~RO_MASK & ~RSVD_MASK;
  localparam logic [WIDTH-1:0] RSVD_KEEP = RSVD_MASK & ~CLR_ON_RD;

  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r1_reset_value: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> (rd_data == RESET_VAL) && !err_one && !err_zero);

  a_r2_ro_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> ((rd_data & RO_MASK) == (($past(rd_data) | $past(hw_set)) & RO_MASK)));

  a_r3_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & W1C_EFF & $past(wr_mask & wr_data & ~hw_set)) == '0));

  a_r4_cor_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> ((rd_data & CLR_ON_RD & ~$past(hw_set)) == '0));

  a_r5_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rd_data & RSVD_KEEP) == (($past(rd_data) | $past(hw_set)) & RSVD_KEEP)));

  a_r6_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (((rd_data ^ ($past(rd_data) | $past(hw_set))) & ~$past(wr_mask) & ~CLR_ON_RD) == '0));

  a_r8_err_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_mask & wr_data & ERR1_MASK)) |=> err_one);

  a_r9_err_zero_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && |(wr_mask & ~wr_data & ERR0_MASK)) |=> err_zero);

  a_r8_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!err_one && !err_zero));

  a_r10_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((rd_data & $past(hw_set)) == $past(hw_set)));
endmodule

bind policy_reg policy_reg_checker #(
  .WIDTH(WIDTH), .RESET_VAL(RESET_VAL), .RO_MASK(RO_MASK), .W1C_MASK(W1C_MASK),
  .COR_MASK(COR_MASK), .RSVD_MASK(RSVD_MASK), .ERR1_MASK(ERR1_MASK), .ERR0_MASK(ERR0_MASK)
) i_policy_reg_checker (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
  .rd_en(rd_en), .rd_data(rd_data), .hw_set(hw_set), .err_one(err_one), .err_zero(err_zero)
);

// File: tb/test_policy_reg.sv
module test_policy_reg;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam logic [W-1:0] P_RST  = 16'hA5C3;
  localparam logic [W-1:0] P_RO   = 16'hF000;
  localparam logic [W-1:0] P_W1C  = 16'h0F00;
  localparam logic [W-1:0] P_COR  = 16'h81F0;
  localparam logic [W-1:0] P_RSVD = 16'h000C;
  localparam logic [W-1:0] P_E1   = 16'h0002;
  localparam logic [W-1:0] P_E0   = 16'h0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [W-1:0] wr_data = '0, wr_mask = '0, hw_set = '0;
  logic [W-1:0] rd_data;
  logic err_one, err_zero;

  int unsigned checks = 0, errors = 0;
  logic [W-1:0] exp_q;
  logic exp_e1, exp_e0;

  always #(CLK_PERIOD/2) clk = ~clk;

  policy_reg #(
    .WIDTH(W), .RESET_VAL(P_RST), .RO_MASK(P_RO), .W1C_MASK(P_W1C), .COR_MASK(P_COR),
    .RSVD_MASK(P_RSVD), .ERR1_MASK(P_E1), .ERR0_MASK(P_E0)
  ) i_policy_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_en(rd_en), .rd_data(rd_data), .hw_set(hw_set), .err_one(err_one), .err_zero(err_zero)
  );

  // Requirement-level model: walk the bits and apply each rule by priority
  function automatic logic [W-1:0] model(logic [W-1:0] q, logic we, logic [W-1:0] wd,
                                         logic [W-1:0] wm, logic re, logic [W-1:0] hs);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[i] = q[i];
      if (P_RO[i]) begin
        r[i] = q[i];                      // R2
      end else begin
        if (we && wm[i] && !P_RSVD[i]) begin
          if (P_W1C[i]) r[i] = wd[i] ? 1'b0 : q[i];   // R3
          else          r[i] = wd[i];                 // R7
        end
        if (re && P_COR[i]) r[i] = 1'b0;              // R4
      end
      if (hs[i]) r[i] = 1'b1;                         // R10
    end
    return r;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One access: drive at the falling edge, check the read value,
  // then check state and error pulses just after the rising edge
  task automatic step(string req, logic we, logic [W-1:0] wd, logic [W-1:0] wm,
                      logic re, logic [W-1:0] hs);
    @(negedge clk);
    wr_en = we; wr_data = wd; wr_mask = wm; rd_en = re; hw_set = hs;
    #1;
    chk({req, " read value"}, rd_data, exp_q);
    @(posedge clk);
    exp_q  = model(exp_q, we, wd, wm, re, hs);
    exp_e1 = we && ((wm & wd & P_E1) != '0);
    exp_e0 = we && ((wm & ~wd & P_E0) != '0);
    #1;
    chk({req, " state"}, rd_data, exp_q);
    chk({req, " err_one"}, {15'd0, err_one}, {15'd0, exp_e1});
    chk({req, " err_zero"}, {15'd0, err_zero}, {15'd0, exp_e0});
  endtask

  task automatic idle();
    step("idle", 1'b0, '0, '0, 1'b0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned sd;
    sd = $urandom(32'd20240611);
    exp_q = P_RST;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset hold", rd_data, P_RST);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reset value", rd_data, P_RST);
    chk("R1 reset err", {14'd0, err_one, err_zero}, '0);

    // R2: read-only bits ignore writes and reads (bit 15 is also clear-on-read)
    step("R2", 1'b1, 16'h0000, 16'hF000, 1'b1, '0);
    chk("R2 ro kept", rd_data & P_RO, 16'hA000);

    // R3: set W1C bits by hardware, then clear two of them by writing ones
    step("R10 set", 1'b0, '0, '0, 1'b0, 16'h0F00);
    step("R3", 1'b1, 16'h0500, 16'h0F00, 1'b0, '0);
    chk("R3 w1c", rd_data & P_W1C, 16'h0A00);

    // R7: plain write on clear-on-read bits
    step("R7", 1'b1, 16'h00F0, 16'h00F0, 1'b0, '0);
    chk("R7 plain write", rd_data & 16'h00F0, 16'h00F0);

    // R4: read returns value, then clears bits 8 and 7:4 but not 15
    step("R4", 1'b0, '0, '0, 1'b1, '0);
    chk("R4 cor cleared", rd_data & 16'h81F0, 16'h8000);

    // R4: write and read together, the clear comes last
    step("R4 same cycle", 1'b1, 16'h0030, 16'h0030, 1'b1, '0);
    chk("R4 clear after write", rd_data & 16'h0030, 16'h0000);

    // R5: reserved bits ignore writes
    step("R5", 1'b1, 16'hFFFF, 16'h000C, 1'b0, '0);
    chk("R5 rsvd kept", rd_data & P_RSVD, 16'h0000);

    // R6: only the enabled bits change
    step("R6 prep", 1'b1, 16'h00F0, 16'h00F0, 1'b0, '0);
    step("R6", 1'b1, 16'h0000, 16'h0030, 1'b0, '0);
    chk("R6 unselected kept", rd_data & 16'h00F0, 16'h00C0);

    // R8: forbidden one on bit 1, then the pulse ends; masked-off data is not an error
    step("R8", 1'b1, 16'h0002, 16'h0002, 1'b0, '0);
    chk("R8 write applied", rd_data & 16'h0002, 16'h0002);
    idle();
    step("R8 masked", 1'b1, 16'h0002, 16'h0000, 1'b0, '0);

    // R9: forbidden zero on bit 0
    step("R9", 1'b1, 16'h0000, 16'h0001, 1'b0, '0);
    chk("R9 write applied", rd_data & 16'h0001, 16'h0000);
    idle();

    // R10: hardware set beats write-one-clear, read clear and read-only
    step("R10 vs w1c", 1'b1, 16'h0100, 16'h0100, 1'b1, 16'h0100);
    chk("R10 kept set", rd_data & 16'h0100, 16'h0100);
    step("R10 vs ro", 1'b1, 16'h0000, 16'h4000, 1'b0, 16'h4000);
    chk("R10 ro set", rd_data & 16'h4000, 16'h4000);

    // Random mix across all classes
    for (int n = 0; n < 3000; n++) begin
      logic [W-1:0] hs;
      hs = (($urandom % 4) == 0) ? 16'($urandom) & 16'($urandom) : '0;
      step("R6 random", ($urandom % 2) == 1, 16'($urandom), 16'($urandom),
           ($urandom % 3) == 0, hs);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule